// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block manages a bank of general-purpose pins behind a 32-bit memory-mapped register port with an APB-style access pattern. Software sets each pin's direction and drives outputs through write-one set and clear registers, so a change to one pin needs no read-modify-write. It can also load the whole output word directly. Inputs pass through a two-stage synchronizer and, per pin, an optional stability filter. The synchronized levels can be read back.

Each pin has its own event detector. Three independent configuration bits choose the trigger. The first picks level or edge. The second picks one edge or both edges. The third picks the active sense: high or rising when 1, low or falling when 0. Edge events stay latched until software acknowledges them by writing ones. Level status tracks the pin condition directly. A masked view combines the raw events with a per-pin enable and a per-pin block bit. One interrupt line to the parent controller is the OR of that masked view.

The register bus and the pin and interrupt signals are all plain control and status. None of them carries a data stream, so there is no valid/ready handshake and no back-pressure: every access finishes in its enable cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every readable register returns 0, `pin_oe` and `pin_out` are all 0 and `irq_out` is 0.
- R2: Offset 0x00 holds the per-pin direction. A 1 makes the pin an output and appears on `pin_oe` the cycle after the write.
- R3: A 1 written to bit i at offset 0x08 drives `pin_out[i]` high. A 1 at offset 0x0C drives it low. Zero bits leave the output as it was. Offset 0x10 reads the output word and a write there loads it whole. Offsets 0x08 and 0x0C read as 0.
- R4: Offset 0x14 returns the pin levels after two synchronizer flops.
- R5: A sense bit of 1 (offset 0x1C) selects level detection. The pin's raw status (offset 0x28) then equals the conditioned input, inverted when its polarity bit (offset 0x24) is 0, one cycle later. An acknowledge write cannot clear it.
- R6: A sense bit of 0 selects edge detection. With the both-edges bit at 0, a polarity of 1 catches rising edges and 0 catches falling edges. The raw status bit then holds until it is acknowledged.
- R7: With edge detection and the both-edges bit (offset 0x20) at 1, either transition sets the raw status and the polarity bit has no effect.
- R8: A 1 written to bit i at offset 0x34 clears a latched edge status. If an edge arrives in the same cycle, the status stays set. Zero bits have no effect and the offset reads as 0.
- R9: Offset 0x30 reads raw status AND enable (offset 0x18) AND NOT block (offset 0x2C). `irq_out` is 1 exactly when that word is non-zero.
- R10: With the filter bit set (offset 0x38), a pin's conditioned input takes a new synchronized value only after the two have differed for L+1 consecutive cycles. L is the low 8 bits at offset 0x3C, which read back. With the filter bit clear, the conditioned input is the synchronized value.
- R11: Offset 0x04 and any unmapped or unaligned offset read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Access select |
| penable | input | 1 | Access enable phase; a write takes effect on the edge that ends it |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 6 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from `paddr` without a register |
| pin_in | input | N (32) | Pin levels, asynchronous |
| pin_out | output | N (32) | Output levels |
| pin_oe | output | N (32) | Output enable per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The properties assume a well-formed access. A write is recognised only in the enable phase with select asserted, and `paddr` and `pwdata` hold steady through that phase. They also assume that `pin_in` changes only between clock edges. The stimulus drives every bus field and every pin level one time unit after a rising edge, from tasks that always pair a setup cycle with an enable cycle. The latched-edge property is stated only for cycles with no write, because a write may change the sense bit and so legitimately drop a latched edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_AW = 6;
  localparam int BUS_W  = 32;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t A_DIR   = 6'h00;
  localparam reg_addr_t A_RSVD  = 6'h04;
  localparam reg_addr_t A_SET   = 6'h08;
  localparam reg_addr_t A_CLR   = 6'h0C;
  localparam reg_addr_t A_OUT   = 6'h10;
  localparam reg_addr_t A_IN    = 6'h14;
  localparam reg_addr_t A_IEN   = 6'h18;
  localparam reg_addr_t A_SENSE = 6'h1C;
  localparam reg_addr_t A_BOTH  = 6'h20;
  localparam reg_addr_t A_POL   = 6'h24;
  localparam reg_addr_t A_RAW   = 6'h28;
  localparam reg_addr_t A_BLOCK = 6'h2C;
  localparam reg_addr_t A_MSTAT = 6'h30;
  localparam reg_addr_t A_ACK   = 6'h34;
  localparam reg_addr_t A_FLTEN = 6'h38;
  localparam reg_addr_t A_FLTLIM = 6'h3C;
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int N  = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_in,
  input  logic [N-1:0]  flt_en,
  input  logic [CW-1:0] flt_lim,
  output logic [N-1:0]  sync_q,
  output logic [N-1:0]  clean
);
  logic [N-1:0] meta_q, stab_q, filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= pin_in;
      stab_q <= meta_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_flt
    logic [CW-1:0] run_q;
    logic          held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q  <= '0;
        held_q <= 1'b0;
      end else if (stab_q[i] == held_q) begin
        run_q <= '0;
      end else if (run_q == flt_lim) begin
        held_q <= stab_q[i];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
    assign filt[i] = held_q;
  end

  assign sync_q = stab_q;
  assign clean  = (flt_en & filt) | (~flt_en & stab_q);
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] clean,
  input  logic [N-1:0] lvl_sel,
  input  logic [N-1:0] both_sel,
  input  logic [N-1:0] pol_sel,
  input  logic [N-1:0] ack,
  output logic [N-1:0] raw
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= clean;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rise, fall, hit, cond, st_q;
    assign rise = clean[i] & ~prev_q[i];
    assign fall = ~clean[i] & prev_q[i];
    assign hit  = both_sel[i] ? (rise | fall) : (pol_sel[i] ? rise : fall);
    assign cond = pol_sel[i] ? clean[i] : ~clean[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          st_q <= 1'b0;
      else if (lvl_sel[i]) st_q <= cond;
      else                 st_q <= (st_q & ~ack[i]) | hit;
    end
    assign raw[i] = st_q;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int N  = 32,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [REG_AW-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq_out
);
  logic         wr;
  logic [N-1:0] wd;
  logic [N-1:0] dir_q, out_q, ien_q, sense_q, both_q, pol_q, block_q, flten_q;
  logic [CW-1:0] fltlim_q;
  logic [N-1:0] sync_q, clean, raw, ack, masked;

  assign wr = psel & penable & pwrite;
  assign wd = pwdata[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      out_q    <= '0;
      ien_q    <= '0;
      sense_q  <= '0;
      both_q   <= '0;
      pol_q    <= '0;
      block_q  <= '0;
      flten_q  <= '0;
      fltlim_q <= '0;
    end else if (wr) begin
      case (paddr)
        A_DIR:    dir_q    <= wd;
        A_SET:    out_q    <= out_q | wd;
        A_CLR:    out_q    <= out_q & ~wd;
        A_OUT:    out_q    <= wd;
        A_IEN:    ien_q    <= wd;
        A_SENSE:  sense_q  <= wd;
        A_BOTH:   both_q   <= wd;
        A_POL:    pol_q    <= wd;
        A_BLOCK:  block_q  <= wd;
        A_FLTEN:  flten_q  <= wd;
        A_FLTLIM: fltlim_q <= pwdata[CW-1:0];
        default: ;
      endcase
    end
  end

  assign ack = (wr && paddr == A_ACK) ? wd : '0;

  gpio_in_cond #(.N(N), .CW(CW)) u_cond (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .flt_en(flten_q),
    .flt_lim(fltlim_q), .sync_q(sync_q), .clean(clean)
  );

  gpio_evt_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_n), .clean(clean), .lvl_sel(sense_q),
    .both_sel(both_q), .pol_sel(pol_q), .ack(ack), .raw(raw)
  );

  assign masked  = raw & ien_q & ~block_q;
  assign irq_out = |masked;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    prdata = '0;
    case (paddr)
      A_DIR:    prdata = BUS_W'(dir_q);
      A_OUT:    prdata = BUS_W'(out_q);
      A_IN:     prdata = BUS_W'(sync_q);
      A_IEN:    prdata = BUS_W'(ien_q);
      A_SENSE:  prdata = BUS_W'(sense_q);
      A_BOTH:   prdata = BUS_W'(both_q);
      A_POL:    prdata = BUS_W'(pol_q);
      A_RAW:    prdata = BUS_W'(raw);
      A_BLOCK:  prdata = BUS_W'(block_q);
      A_MSTAT:  prdata = BUS_W'(masked);
      A_FLTEN:  prdata = BUS_W'(flten_q);
      A_FLTLIM: prdata = BUS_W'(fltlim_q);
      default:  prdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [REG_AW-1:0] paddr,
  input logic [BUS_W-1:0]  pwdata,
  input logic [N-1:0]      pin_out,
  input logic [N-1:0]      pin_oe,
  input logic              irq_out,
  input logic [N-1:0]      ien_q,
  input logic [N-1:0]      raw_q,
  input logic [N-1:0]      sense_q,
  input logic [N-1:0]      block_q
);
  logic wr;
  assign wr = psel && penable && pwrite;

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!irq_out && pin_oe == '0 && pin_out == '0));

  p_set_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == A_SET) |=>
      ((pin_out & $past(pwdata[N-1:0])) == $past(pwdata[N-1:0])));

  p_clear_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == A_CLR) |=> ((pin_out & $past(pwdata[N-1:0])) == '0));

  p_edge_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((raw_q & $past(raw_q & ~sense_q)) == $past(raw_q & ~sense_q)));

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ien_q != '0));

  p_block_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&block_q) |-> !irq_out);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_out(irq_out), .ien_q(ien_q), .raw_q(raw), .sense_q(sense_q),
  .block_q(block_q)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;

  int checks = 0, failures = 0;
  bit running = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // behavioural reference state
  logic [31:0] m_dir, m_out, m_ien, m_sense, m_both, m_pol, m_block, m_flt;
  logic [31:0] m_s1, m_s2, m_filt, m_prev, m_raw;
  logic [7:0]  m_lim;
  int          m_cnt [32];
  logic [31:0] t_clean, t_rise, t_fall, t_ev, t_lvl, t_clr, t_nraw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_out = 0; m_ien = 0; m_sense = 0; m_both = 0; m_pol = 0;
      m_block = 0; m_flt = 0; m_lim = 0; m_s1 = 0; m_s2 = 0; m_filt = 0;
      m_prev = 0; m_raw = 0;
      foreach (m_cnt[k]) m_cnt[k] = 0;
    end else begin
      t_clean = (m_flt & m_filt) | (~m_flt & m_s2);
      t_rise  = t_clean & ~m_prev;
      t_fall  = ~t_clean & m_prev;
      t_clr   = (psel && penable && pwrite && paddr == 6'h34) ? pwdata : 0;
      for (int i = 0; i < 32; i++) begin
        t_lvl[i] = m_pol[i] ? t_clean[i] : !t_clean[i];
        if (m_both[i]) t_ev[i] = t_rise[i] | t_fall[i];
        else           t_ev[i] = m_pol[i] ? t_rise[i] : t_fall[i];
        t_nraw[i] = m_sense[i] ? t_lvl[i] : ((m_raw[i] & !t_clr[i]) | t_ev[i]);
        if (m_s2[i] == m_filt[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == int'(m_lim)) begin m_filt[i] = m_s2[i]; m_cnt[i] = 0; end
        else m_cnt[i] = m_cnt[i] + 1;
      end
      m_raw  = t_nraw;
      m_prev = t_clean;
      m_s2   = m_s1;
      m_s1   = pin_in;
      if (psel && penable && pwrite) begin
        case (paddr)
          6'h00: m_dir = pwdata;
          6'h08: m_out = m_out | pwdata;
          6'h0C: m_out = m_out & ~pwdata;
          6'h10: m_out = pwdata;
          6'h18: m_ien = pwdata;
          6'h1C: m_sense = pwdata;
          6'h20: m_both = pwdata;
          6'h24: m_pol = pwdata;
          6'h2C: m_block = pwdata;
          6'h38: m_flt = pwdata;
          6'h3C: m_lim = pwdata[7:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h00: return m_dir;
      6'h10: return m_out;
      6'h14: return m_s2;
      6'h18: return m_ien;
      6'h1C: return m_sense;
      6'h20: return m_both;
      6'h24: return m_pol;
      6'h28: return m_raw;
      6'h2C: return m_block;
      6'h30: return m_raw & m_ien & ~m_block;
      6'h38: return m_flt;
      6'h3C: return {24'h0, m_lim};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00: return "R2";
      6'h08, 6'h0C, 6'h10: return "R3";
      6'h14: return "R4";
      6'h1C, 6'h24: return "R5";
      6'h28: return "R6";
      6'h20: return "R7";
      6'h34: return "R8";
      6'h18, 6'h2C, 6'h30: return "R9";
      6'h38, 6'h3C: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (running && rst_n) begin
      check("R2", "pin_oe", pin_oe, m_dir);
      check("R3", "pin_out", pin_out, m_out);
      check("R9", "irq_out", {31'h0, irq_out}, {31'h0, |(m_raw & m_ien & ~m_block)});
      check(tag_of(paddr), "prdata", prdata, exp_rd(paddr));
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    tick();
    penable = 1;
    tick();
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] v);
    paddr = a;
    @(negedge clk);
    v = prdata;
    tick();
  endtask

  logic [31:0] v;

  initial begin
    tick(3);
    rst_n = 1;
    running = 1;
    tick();
    // R1: every register reads zero after reset
    for (int a = 0; a < 64; a += 4) begin
      peek(6'(a), v);
      check("R1", "reset read", v, 0);
    end
    check("R1", "reset irq_out", {31'h0, irq_out}, 0);

    // R2 / R3: direction and output control
    bus_write(6'h00, 32'h0000_FFFF);
    bus_write(6'h08, 32'h0000_F0F0);
    bus_write(6'h0C, 32'h0000_00F0);
    check("R3", "set then clear", pin_out, 32'h0000_F000);
    bus_write(6'h08, 32'h0);
    check("R3", "zero set no change", pin_out, 32'h0000_F000);
    bus_write(6'h10, 32'hA5A5_0003);
    check("R3", "direct load", pin_out, 32'hA5A5_0003);
    check("R2", "direction", pin_oe, 32'h0000_FFFF);

    // R11: reserved offset
    bus_write(6'h04, 32'hFFFF_FFFF);
    peek(6'h04, v);
    check("R11", "reserved read", v, 0);

    // R4: synchronized input
    pin_in = 32'h1234_5600;
    tick(3);
    peek(6'h14, v);
    check("R4", "input read", v, 32'h1234_5600);
    pin_in = 0;
    tick(3);

    // trigger setup: pin0 rising, pin1 falling, pin2/6 both, pin3 level high,
    // pin4 level low, pin5 filtered rising
    bus_write(6'h24, 32'h0000_0029);
    bus_write(6'h1C, 32'h0000_0018);
    bus_write(6'h20, 32'h0000_0044);
    bus_write(6'h18, 32'hFFFF_FFFF);
    bus_write(6'h3C, 32'h0000_0003);
    bus_write(6'h38, 32'h0000_0020);
    tick(2);
    peek(6'h28, v);
    check("R5", "level low while pin low", {31'h0, v[4]}, 1);

    // R6 rising edge on pin0
    pin_in[0] = 1; tick(5);
    peek(6'h28, v);
    check("R6", "rising latched", {31'h0, v[0]}, 1);
    bus_write(6'h34, 32'h0000_0001);
    peek(6'h28, v);
    check("R8", "ack clears", {31'h0, v[0]}, 0);
    pin_in[0] = 0; tick(5);
    peek(6'h28, v);
    check("R6", "falling ignored on rising pin", {31'h0, v[0]}, 0);

    // R7 both edges on pin2 (polarity 0)
    pin_in[2] = 1; tick(5);
    peek(6'h28, v);
    check("R7", "rise on both-edge pin", {31'h0, v[2]}, 1);

    // R5 level high on pin3, ack has no effect
    pin_in[3] = 1; tick(5);
    bus_write(6'h34, 32'h0000_0008);
    peek(6'h28, v);
    check("R5", "level survives ack", {31'h0, v[3]}, 1);
    pin_in[3] = 0; tick(5);
    peek(6'h28, v);
    check("R5", "level follows pin", {31'h0, v[3]}, 0);

    // R8 edge in the same cycle as the ack
    pin_in[6] = 1; tick(5);
    pin_in[6] = 0; tick();
    bus_write(6'h34, 32'h0000_0040);
    peek(6'h28, v);
    check("R8", "edge wins over ack", {31'h0, v[6]}, 1);
    bus_write(6'h34, 32'h0000_0040);
    peek(6'h28, v);
    check("R8", "later ack clears", {31'h0, v[6]}, 0);

    // R10 debounce on pin5: short glitch filtered, long pulse passes
    pin_in[5] = 1; tick(2); pin_in[5] = 0; tick(8);
    peek(6'h28, v);
    check("R10", "glitch filtered", {31'h0, v[5]}, 0);
    pin_in[5] = 1; tick(10);
    peek(6'h28, v);
    check("R10", "stable pulse passes", {31'h0, v[5]}, 1);

    // R9 blocking
    check("R9", "irq pending", {31'h0, irq_out}, 1);
    bus_write(6'h2C, 32'hFFFF_FFFF);
    check("R9", "all blocked", {31'h0, irq_out}, 0);
    bus_write(6'h2C, 32'h0);

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      pin_in = $urandom;
      if (n % 3 == 0) begin
        logic [5:0] a;
        logic [31:0] d;
        a = 6'($urandom_range(0, 15) * 4);
        d = $urandom;
        if (a == 6'h3C) d = d & 32'h3;
        bus_write(a, d);
      end else begin
        paddr = 6'($urandom_range(0, 15) * 4);
        tick();
      end
    end
    tick(2);

    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule